// File: doc/BRIEF.md
# Command/Data Serial Slave Port

This block is the serial access port of a converter-style device. An external master drives a select line, a bit clock and a data input. The block returns data on one output line, together with an enable that tells the pad when to drive. Every access opens with an 8-bit command word. That word either starts a 32-bit data phase into or out of one of eight internal registers, or it requests a conversion. The register storage sits outside this block. The port only produces an address, a write strobe with its data word, and it samples a read data bus.

After a conversion request, the output line becomes a busy/ready flag. It stays high until the converter reports a finished result, and then it falls low. The master answers with eight clocks of zeros to clear the flag, then clocks out the 32-bit result. If any of those eight clear bits is nonzero, the byte is taken as a new command instead. With the select line tied low, the port runs as a three-wire link. In that mode it can be brought back to a known point with a run of ones followed by a zero.

All serial pins are synchronized into the system clock. The port acts on detected rising and falling edges of the bit clock, so the bit clock must be well below a quarter of the system clock rate.

Top module: `adc_serial_port`

## Requirements
- R1: While `csn` is high, `sdo_oe` is 0, bit-clock edges have no effect, and the port returns to waiting for a command. A transaction interrupted by `csn` going high produces no write.
- R2: A command is 8 bits, sampled on `sclk` rising edges, MSB first. Command bit 7 = 1 selects read and 0 selects write. Bits 6:4 give the register address. Bits 3:1 are ignored. Bit 0 = 1 requests a conversion.
- R3: A write command (bit 7 = 0, bit 0 = 0) is followed by 32 bits on `sdi`, MSB first. After the 32nd rising edge, `reg_wr_en` pulses for exactly one clock, with the command's address on `reg_addr` and the word on `reg_wdata`.
- R4: A read command (bit 7 = 1, bit 0 = 0) samples `reg_rdata` for the addressed register. The MSB is placed on `sdo` before the first data rising edge, each later bit follows a falling edge, and the LSB is the 32nd bit.
- R5: A command with bit 0 = 1 pulses `conv_start` for one clock and starts no data phase, whatever bits 7:1 hold. `conv_start` and `reg_wr_en` never pulse together.
- R6: After a conversion request, `sdo` is 1 until `conv_done` pulses. On that pulse `conv_result` is captured and `sdo` goes to 0.
- R7: With the flag low, eight clocks with `sdi` = 0 clear it. The next 32 clocks shift out the captured result, MSB first, after which the port waits for a command.
- R8: If the eight clear bits are not all zero, the result readout is abandoned and those eight bits are decoded as a command under R2.
- R9: In any state, a zero on `sdi` at a rising edge that follows 31 or more consecutive ones returns the port to waiting for a command. That zero bit is consumed.
- R10: With `csn` held low throughout, commands and data phases follow one another back to back without framing.
- R11: After reset, with `csn` high, `sdo_oe`, `reg_wr_en` and `conv_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial bit clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data / ready flag to the master |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad (0 = high impedance) |
| reg_addr | output | 3 | Register address from the last command |
| reg_wr_en | output | 1 | One-clock write strobe |
| reg_wdata | output | 32 | Write data word |
| reg_rdata | input | 32 | Read data for `reg_addr` |
| conv_start | output | 1 | One-clock conversion request |
| conv_done | input | 1 | One-clock pulse: conversion result valid |
| conv_result | input | 32 | Conversion result word |

## Verification
The write/read path is driven with data words chosen to separate ordering faults:
- all zeros;
- a word with only its end bits set, which exposes MSB/LSB reversal and an off-by-one shift;
- an ascending nibble pattern;
- half-ones/half-zeros words;
- a word with set reserved command bits, which shows that bits 3:1 are ignored.

Each vector goes to a distinct address, so an address-decode fault surfaces on readback. The conversion path is tried two ways: with an all-zero clear byte, where the result must appear, and with a nonzero byte, where a register read must appear instead. The resync sequence is entered from inside a conversion wait, where a port that ignored resync would keep its flag high.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 32,
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int RESYNC_ONES = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int ONES_W = $clog2(RESYNC_ONES + 1);
  localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0]  WORD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ONES_W-1:0] ONES_MAX  = ONES_W'(RESYNC_ONES);

  typedef enum logic [2:0] {S_CMD, S_WR, S_LOAD, S_RD, S_WAIT, S_CLR, S_RES} state_t;

  state_t            state;
  logic [2:0]        sclk_q;
  logic [1:0]        csn_q, sdi_q;
  logic [CMD_W-1:0]  cmd_sh;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [ONES_W-1:0] ones;

  wire active = ~csn_q[1];
  wire bit_in = sdi_q[1];
  wire rise   = active & sclk_q[1] & ~sclk_q[2];
  wire fall   = active & ~sclk_q[1] & sclk_q[2];
  wire resync = rise & ~bit_in & (ones == ONES_MAX);
  wire [CMD_W-1:0] cmd_next = {cmd_sh[CMD_W-2:0], bit_in};

  assign sdo_oe    = active;
  assign reg_wdata = shreg;

  always_comb begin
    case (state)
      S_RD, S_RES: sdo = shreg[DATA_W-1];
      S_WAIT:      sdo = 1'b1;
      default:     sdo = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      csn_q  <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      csn_q  <= {csn_q[0], csn};
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_CMD;
      cmd_sh     <= '0;
      shreg      <= '0;
      cnt        <= '0;
      ones       <= '0;
      reg_addr   <= '0;
      reg_wr_en  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      conv_start <= 1'b0;
      if (rise) ones <= !bit_in ? '0 : (ones == ONES_MAX) ? ones : ones + 1'b1;
      if (!active || resync) begin
        state <= S_CMD;
        cnt   <= '0;
      end else begin
        case (state)
          S_CMD, S_CLR: if (rise) begin
            cmd_sh <= cmd_next;
            cnt    <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              if (state == S_CLR && cmd_next == '0) begin
                state <= S_RES;
              end else if (cmd_next[0]) begin
                conv_start <= 1'b1;
                state      <= S_WAIT;
              end else begin
                reg_addr <= cmd_next[CMD_W-2 -: ADDR_W];
                state    <= cmd_next[CMD_W-1] ? S_LOAD : S_WR;
              end
            end
          end
          S_WR: if (rise) begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
            cnt   <= cnt + 1'b1;
            if (cnt == WORD_LAST) begin
              cnt       <= '0;
              reg_wr_en <= 1'b1;
              state     <= S_CMD;
            end
          end
          S_LOAD: begin
            shreg <= reg_rdata;
            state <= S_RD;
          end
          S_RD, S_RES: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == WORD_LAST) begin
                cnt   <= '0;
                state <= S_CMD;
              end
            end else if (fall && cnt != '0) begin
              shreg <= {shreg[DATA_W-2:0], 1'b0};
            end
          end
          S_WAIT: if (conv_done) begin
            shreg <= conv_result;
            state <= S_CLR;
          end
          default: state <= S_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_serial_port_checks.sv
module adc_serial_port_checks #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn,
  input logic              sdo_oe,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic              conv_start
);
  assert_pad_off_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> !sdo_oe);

  assert_no_action_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> (!reg_wr_en && !conv_start));

  assert_single_write_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_addr_held_at_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $stable(reg_addr));

  assert_single_conv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_conv_excludes_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && reg_wr_en));
endmodule

bind adc_serial_port adc_serial_port_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .csn(csn), .sdo_oe(sdo_oe),
  .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .conv_start(conv_start)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, reg_wr_en, conv_start;
  logic        conv_done = 1'b0;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] conv_result = '0;

  logic [31:0] regs [8];
  logic [31:0] exp_regs [8];
  int          wr_cnt = 0, conv_cnt = 0, checks = 0, fails = 0;
  logic [2:0]  last_a;
  logic [31:0] last_d;

  always #4 clk = ~clk;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (reg_wr_en) begin
      regs[reg_addr] <= reg_wdata;
      last_a <= reg_addr;
      last_d <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (conv_start) conv_cnt <= conv_cnt + 1;
  end

  // {address, data}
  localparam logic [34:0] VEC [6] = '{
    {3'd0, 32'h0000_0000}, {3'd1, 32'h8000_0001}, {3'd2, 32'h1234_5678},
    {3'd3, 32'hFFFF_0000}, {3'd4, 32'h7FFF_FFFE}, {3'd5, 32'h00FF_A55A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    sdi = b;
    wait_clk(6);
    r = sdo;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic r;
    for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], r);
  endtask

  task automatic recv_word(output logic [31:0] v);
    logic r;
    for (int i = 31; i >= 0; i--) begin
      xfer_bit(1'b0, r);
      v[i] = r;
    end
  endtask

  task automatic frame_open;
    csn = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame_close;
    wait_clk(6);
    csn = 1'b1;
    wait_clk(6);
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
    send_bits({24'd0, 1'b1, a, 4'b0000}, 8);
    recv_word(v);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          w0, c0;
    for (int i = 0; i < 8; i++) begin
      regs[i] = 32'hDEAD_0000 | 32'(i);
      exp_regs[i] = 32'hDEAD_0000 | 32'(i);
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R11 sdo_oe after reset", {31'd0, sdo_oe}, 32'd0);
    check("R11 strobes after reset", {30'd0, reg_wr_en, conv_start}, 32'd0);

    // R2 R3 R4: table of write-then-read vectors, framed by csn
    for (int k = 0; k < 6; k++) begin
      logic [2:0]  a;
      logic [31:0] d;
      logic [3:0]  rsv;
      a = VEC[k][34:32];
      d = VEC[k][31:0];
      rsv = (k == 5) ? 4'b1110 : 4'b0000;
      w0 = wr_cnt;
      frame_open;
      check("R1 sdo_oe while selected", {31'd0, sdo_oe}, 32'd1);
      send_bits({24'd0, 1'b0, a, rsv}, 8);
      send_bits(d, 32);
      wait_clk(2);
      exp_regs[a] = d;
      check("R3 one write strobe", 32'(wr_cnt - w0), 32'd1);
      check("R3 write address", {29'd0, last_a}, {29'd0, a});
      check("R3 write data MSB first", last_d, d);
      frame_close;
      frame_open;
      read_reg(a, rd);
      check("R4 readback MSB first", rd, exp_regs[a]);
      frame_close;
    end

    // R1: write aborted by csn, then edges while deselected
    w0 = wr_cnt;
    frame_open;
    send_bits({24'd0, 8'b0_010_0000}, 8);
    send_bits(32'h3FF, 10);
    csn = 1'b1;
    wait_clk(6);
    check("R1 sdo_oe after deselect", {31'd0, sdo_oe}, 32'd0);
    send_bits({24'd0, 8'b0_010_0000}, 8);
    send_bits(32'hCAFE_F00D, 32);
    wait_clk(4);
    check("R1 no write from aborted/deselected traffic", 32'(wr_cnt - w0), 32'd0);
    frame_open;
    read_reg(3'd2, rd);
    check("R1 register unchanged", rd, exp_regs[2]);
    frame_close;

    // R5 R6 R7: conversion with read bit and address also set
    w0 = wr_cnt;
    c0 = conv_cnt;
    frame_open;
    send_bits({24'd0, 8'hF1}, 8);
    wait_clk(8);
    check("R5 conv_start one pulse", 32'(conv_cnt - c0), 32'd1);
    check("R5 no write on conversion", 32'(wr_cnt - w0), 32'd0);
    check("R6 flag high while busy", {31'd0, sdo}, 32'd1);
    conv_result = 32'hC3A5_0F96;
    conv_done = 1'b1;
    wait_clk(1);
    conv_done = 1'b0;
    conv_result = 32'h0;
    wait_clk(3);
    check("R6 flag low when done", {31'd0, sdo}, 32'd0);
    send_bits(32'd0, 8);
    recv_word(rd);
    check("R7 result shifted out", rd, 32'hC3A5_0F96);
    read_reg(3'd3, rd);
    check("R7 command accepted after result", rd, exp_regs[3]);
    frame_close;

    // R8: nonzero clear byte becomes a read of register 1
    frame_open;
    send_bits({24'd0, 8'h01}, 8);
    wait_clk(4);
    conv_result = 32'h5555_AAAA;
    conv_done = 1'b1;
    wait_clk(1);
    conv_done = 1'b0;
    wait_clk(3);
    send_bits({24'd0, 8'b1_001_0000}, 8);
    recv_word(rd);
    check("R8 clear byte decoded as read", rd, exp_regs[1]);
    frame_close;

    // R9 R10: csn tied low from here on
    csn = 1'b0;
    wait_clk(4);
    send_bits(32'd0, 3);
    send_bits(32'h7FFF_FFFF, 31);
    send_bits(32'd0, 1);
    wait_clk(4);
    check("R9 resync leaves conversion wait", {31'd0, sdo}, 32'd0);
    read_reg(3'd4, rd);
    check("R9 command after resync", rd, exp_regs[4]);
    w0 = wr_cnt;
    send_bits({24'd0, 8'b0_110_0000}, 8);
    send_bits(32'h0BAD_BEEF, 32);
    exp_regs[6] = 32'h0BAD_BEEF;
    read_reg(3'd6, rd);
    check("R10 back-to-back write then read", rd, 32'h0BAD_BEEF);
    check("R10 single write strobe", 32'(wr_cnt - w0), 32'd1);
    read_reg(3'd0, rd);
    check("R10 second read back-to-back", rd, exp_regs[0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule